// File: doc/BRIEF.md
# Debug Scan-Chain Register Access Unit

This block is the data-register side of a debug scan chain. A debugger moves 38-bit frames through it with the TAP controller's capture, shift and update strobes. Each frame carries a 32-bit data word, a 5-bit register address and a direction bit. Through these frames the debugger reads and writes a small bank of 32-bit debug registers. The bank holds a debug control word whose monitor-mode bit is brought out to the core, a watchpoint data value, and a two-way communications channel between the debugger and the core.

Reads are pipelined across scans. An update with the direction bit clear only records the address. The capture that begins the next scan loads that register's value, and the value is shifted out while the next frame is shifted in. Reading the channel data word takes the core's pending word and clears its flag. A debugger that streams words out of the channel therefore ends the burst with an address pointing at the harmless control register. The core side runs on the same TCK clock and has a one-cycle read strobe and a one-cycle write strobe.

A scan-phase state machine runs beside the shift register. Its states are `ST_IDLE` (no frame open), `ST_CAPT` (a frame was just captured) and `ST_SHIFT` (bits are moving). Capture moves the machine to `ST_CAPT` from any state. From `ST_CAPT` or `ST_SHIFT`, a shift strobe moves it to `ST_SHIFT`. From `ST_CAPT` or `ST_SHIFT`, an update strobe acts on the frame and returns the machine to `ST_IDLE`. Shift and update strobes seen in `ST_IDLE` have no effect. In every state, a cycle with no strobe holds the state.

Top module: `dbg_scan_regs`

## Requirements
- R1: The frame is 38 bits long: bits 31:0 are data, bits 36:32 are the address, and bit 37 is the direction bit (1 = write, 0 = read). Bits enter at `tdi` least significant bit first, and `tdo` always shows bit 0 of the shift register.
- R2: A read update only latches the address. The next capture loads bits 31:0 with the latched register's value and clears bits 37:32. A write update leaves the latched address unchanged.
- R3: A write update stores bits 31:0 of the frame into the register named by bits 36:32.
- R4: A shift or update strobe that arrives while no frame is open (`ST_IDLE`) leaves the shift register, the latched address and every register unchanged.
- R5: Address 4 is the channel control word. Bits 31:28 hold the parameter VERSION (default 5), bit 1 is the W flag, bit 0 is the R flag, and all other bits read 0. Reading it has no side effect, and writes to it are ignored.
- R6: A debugger write to address 5 stores the word on `core_rdata` and sets R (`core_rx_full`). A core read strobe `core_rd` clears R.
- R7: A core write strobe `core_wr` stores `core_wdata` and sets W (`core_tx_full`). A capture from address 5 returns that word and clears W.
- R8: Address 9 is a read/write debug control word, and its bit 4 drives `monitor_mode`. Address 10 is a read/write watchpoint data value.
- R9: Reads of every other address return zero, and writes to them change nothing.
- R10: The asynchronous reset (`trst_n` low) clears all registers, both flags, the shift register and the latched address, and puts the state machine in `ST_IDLE`.
- R11: When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state is clocked on it |
| trst_n | input | 1 | Asynchronous reset, active low |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the shift register) |
| core_rd | input | 1 | Core takes the debugger-to-core word |
| core_rdata | output | 32 | Debugger-to-core word |
| core_rx_full | output | 1 | R flag: a word is waiting for the core |
| core_wr | input | 1 | Core posts a word for the debugger |
| core_wdata | input | 32 | Word posted by the core |
| core_tx_full | output | 1 | W flag: a word is waiting for the debugger |
| dbg_ctrl | output | 32 | Debug control word |
| wp0_value | output | 32 | Watchpoint data value |
| monitor_mode | output | 1 | Bit 4 of the debug control word |

## Verification
On every cycle, assertions check the flag rules: a core write leaves W set, a core read clears R unless a debugger write to the data word arrives in the same cycle, and a capture that meets a core write leaves W set. They also check that capturing the control word disturbs neither flag, that writes to unimplemented addresses leave the bank stable, and that idle shift or update strobes leave the shift register and the latched address alone. Only the bench's scan sequences show the pipelined read, where each scan returns the register named by the previous scan. They also show the version field, the end-to-end serial bit order, and the read-clears-W side effect as seen from the debugger.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int SCAN_W = DATA_W + ADDR_W + 1;

    localparam logic [ADDR_W-1:0] A_CHAN_CTRL = 5'd4;
    localparam logic [ADDR_W-1:0] A_CHAN_DATA = 5'd5;
    localparam logic [ADDR_W-1:0] A_DBG_CTRL  = 5'd9;
    localparam logic [ADDR_W-1:0] A_WP0_VALUE = 5'd10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAPT  = 2'd1,
        ST_SHIFT = 2'd2
    } scan_state_e;
endpackage

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter
    import dbg_scan_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          tck,
    input  logic          trst_n,
    input  logic          capture_dr,
    input  logic          shift_dr,
    input  logic          update_dr,
    input  logic          tdi,
    output logic          tdo,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          cap_fire,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int SW      = DW + AW + 1;
    localparam int DIR_BIT = SW - 1;

    scan_state_e   state, state_nx;
    logic [SW-1:0] sr;
    logic [AW-1:0] addr_q;
    logic          frame_open;
    logic          upd_ok;
    logic          shift_ok;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (capture_dr) state_nx = ST_CAPT;
            end
            ST_CAPT, ST_SHIFT: begin
                if (capture_dr)     state_nx = ST_CAPT;
                else if (update_dr) state_nx = ST_IDLE;
                else if (shift_dr)  state_nx = ST_SHIFT;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_IDLE;
        else         state <= state_nx;
    end

    // outputs of the phase machine
    always_comb begin
        frame_open = (state != ST_IDLE);
        cap_fire   = capture_dr;
        upd_ok     = update_dr && !capture_dr && frame_open;
        shift_ok   = shift_dr && !capture_dr && !update_dr && frame_open;
        wr_fire    = upd_ok && sr[DIR_BIT];
        wr_addr    = sr[DW +: AW];
        wr_data    = sr[DW-1:0];
        rd_addr    = addr_q;
        tdo        = sr[0];
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr <= '0;
        end else if (capture_dr) begin
            sr <= {{(AW+1){1'b0}}, rd_data};
        end else if (shift_ok) begin
            sr <= {tdi, sr[SW-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                     addr_q <= '0;
        else if (upd_ok && !sr[DIR_BIT]) addr_q <= sr[DW +: AW];
    end

    assert_idle_shift_ignored_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IDLE && !capture_dr) |=> $stable(sr));

    assert_idle_update_ignored_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IDLE && update_dr && !capture_dr) |=> $stable(addr_q));

    assert_write_keeps_addr_R2: assert property (@(posedge tck) disable iff (!trst_n)
        wr_fire |=> $stable(rd_addr));
endmodule

// File: rtl/dbg_scan_bank.sv
module dbg_scan_bank
    import dbg_scan_pkg::*;
#(
    parameter int         DW      = DATA_W,
    parameter int         AW      = ADDR_W,
    parameter logic [3:0] VERSION = 4'h5
) (
    input  logic          tck,
    input  logic          trst_n,
    input  logic [AW-1:0] rd_addr,
    input  logic          cap_fire,
    output logic [DW-1:0] rd_data,
    input  logic          wr_fire,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          core_rd,
    output logic [DW-1:0] core_rdata,
    output logic          core_rx_full,
    input  logic          core_wr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_tx_full,
    output logic [DW-1:0] dbg_ctrl,
    output logic [DW-1:0] wp0_value
);
    localparam int PAD_W = DW - 4 - 2;

    logic [DW-1:0] rx_word, tx_word, ctl_q, wp_q;
    logic          rx_full, tx_full;
    logic          dbg_sets_r, dbg_clears_w;

    assign dbg_sets_r   = wr_fire && (wr_addr == A_CHAN_DATA);
    assign dbg_clears_w = cap_fire && (rd_addr == A_CHAN_DATA);

    always_comb begin
        case (rd_addr)
            A_CHAN_CTRL: rd_data = {VERSION, {PAD_W{1'b0}}, tx_full, rx_full};
            A_CHAN_DATA: rd_data = tx_word;
            A_DBG_CTRL:  rd_data = ctl_q;
            A_WP0_VALUE: rd_data = wp_q;
            default:     rd_data = '0;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            rx_word <= '0;
            ctl_q   <= '0;
            wp_q    <= '0;
        end else if (wr_fire) begin
            case (wr_addr)
                A_CHAN_DATA: rx_word <= wr_data;
                A_DBG_CTRL:  ctl_q   <= wr_data;
                A_WP0_VALUE: wp_q    <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            rx_full <= 1'b0;
            tx_full <= 1'b0;
            tx_word <= '0;
        end else begin
            rx_full <= (rx_full && !core_rd) || dbg_sets_r;
            tx_full <= (tx_full && !dbg_clears_w) || core_wr;
            if (core_wr) tx_word <= core_wdata;
        end
    end

    assign core_rdata   = rx_word;
    assign core_rx_full = rx_full;
    assign core_tx_full = tx_full;
    assign dbg_ctrl     = ctl_q;
    assign wp0_value    = wp_q;

    assert_core_wr_sets_w_R7: assert property (@(posedge tck) disable iff (!trst_n)
        core_wr |=> core_tx_full);

    assert_core_rd_clears_r_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (core_rd && !(wr_fire && wr_addr == A_CHAN_DATA)) |=> !core_rx_full);

    assert_set_beats_clear_R11: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_fire && rd_addr == A_CHAN_DATA && core_wr) |=> core_tx_full);

    assert_ctrl_read_quiet_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_fire && rd_addr == A_CHAN_CTRL && !core_rd && !core_wr && !wr_fire)
        |=> ($stable(core_rx_full) && $stable(core_tx_full)));

    assert_unmapped_write_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (wr_fire && wr_addr != A_CHAN_DATA && wr_addr != A_DBG_CTRL && wr_addr != A_WP0_VALUE)
        |=> ($stable(dbg_ctrl) && $stable(wp0_value) && $stable(core_rdata)));
endmodule

// File: rtl/dbg_scan_regs.sv
module dbg_scan_regs
    import dbg_scan_pkg::*;
#(
    parameter int         DW      = DATA_W,
    parameter int         AW      = ADDR_W,
    parameter logic [3:0] VERSION = 4'h5
) (
    input  logic          tck,
    input  logic          trst_n,
    input  logic          capture_dr,
    input  logic          shift_dr,
    input  logic          update_dr,
    input  logic          tdi,
    output logic          tdo,
    input  logic          core_rd,
    output logic [DW-1:0] core_rdata,
    output logic          core_rx_full,
    input  logic          core_wr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_tx_full,
    output logic [DW-1:0] dbg_ctrl,
    output logic [DW-1:0] wp0_value,
    output logic          monitor_mode
);
    localparam int MON_BIT = 4;

    logic [DW-1:0] rd_data, wr_data;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          cap_fire, wr_fire;

    dbg_scan_shifter #(.DW(DW), .AW(AW)) u_shift (
        .tck        (tck),
        .trst_n     (trst_n),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .tdo        (tdo),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .cap_fire   (cap_fire),
        .wr_fire    (wr_fire),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    dbg_scan_bank #(.DW(DW), .AW(AW), .VERSION(VERSION)) u_bank (
        .tck          (tck),
        .trst_n       (trst_n),
        .rd_addr      (rd_addr),
        .cap_fire     (cap_fire),
        .rd_data      (rd_data),
        .wr_fire      (wr_fire),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .core_rd      (core_rd),
        .core_rdata   (core_rdata),
        .core_rx_full (core_rx_full),
        .core_wr      (core_wr),
        .core_wdata   (core_wdata),
        .core_tx_full (core_tx_full),
        .dbg_ctrl     (dbg_ctrl),
        .wp0_value    (wp0_value)
    );

    assign monitor_mode = dbg_ctrl[MON_BIT];

    assert_monitor_tracks_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (wr_fire && wr_addr == A_DBG_CTRL) |=> (monitor_mode == $past(wr_data[MON_BIT])));
endmodule

// File: tb/sim_dbg_scan_regs.sv
module sim_dbg_scan_regs;
    logic        clk = 1'b0;
    logic        trst_n = 1'b0;
    logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic        core_rd = 1'b0, core_wr = 1'b0;
    logic [31:0] core_wdata = '0;
    logic        tdo, core_rx_full, core_tx_full, monitor_mode;
    logic [31:0] core_rdata, dbg_ctrl, wp0_value;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dbg_scan_regs u0 (
        .tck(clk), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .core_rd(core_rd),
        .core_rdata(core_rdata), .core_rx_full(core_rx_full), .core_wr(core_wr),
        .core_wdata(core_wdata), .core_tx_full(core_tx_full), .dbg_ctrl(dbg_ctrl),
        .wp0_value(wp0_value), .monitor_mode(monitor_mode)
    );

    // behavioural reference state
    bit          m_open;
    bit [37:0]   m_frame;
    bit [4:0]    m_sel;
    bit [31:0]   m_ctl, m_wp, m_down, m_up;
    bit          m_r, m_w;

    function automatic bit [31:0] m_peek(input bit [4:0] a);
        if (a == 5'd4)  return {4'h5, 26'd0, m_w, m_r};
        if (a == 5'd5)  return m_up;
        if (a == 5'd9)  return m_ctl;
        if (a == 5'd10) return m_wp;
        return 32'd0;
    endfunction

    task automatic m_reset();
        m_open = 0; m_frame = '0; m_sel = '0; m_ctl = '0; m_wp = '0;
        m_down = '0; m_up = '0; m_r = 0; m_w = 0;
    endtask

    task automatic m_clock();
        bit r_nx = m_r && !core_rd;
        bit w_nx = m_w;
        if (capture_dr) begin
            if (m_sel == 5'd5) w_nx = 0;
            m_frame = {6'd0, m_peek(m_sel)};
            m_open = 1;
        end else if (update_dr) begin
            if (m_open) begin
                if (m_frame[37]) begin
                    case (m_frame[36:32])
                        5'd5:  begin m_down = m_frame[31:0]; r_nx = 1; end
                        5'd9:  m_ctl = m_frame[31:0];
                        5'd10: m_wp = m_frame[31:0];
                        default: ;
                    endcase
                end else begin
                    m_sel = m_frame[36:32];
                end
            end
            m_open = 0;
        end else if (shift_dr && m_open) begin
            m_frame = {tdi, m_frame[37:1]};
        end
        if (core_wr) begin m_up = core_wdata; w_nx = 1; end
        m_r = r_nx;
        m_w = w_nx;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one clock: advance design and model, then compare every output
    task automatic step();
        @(posedge clk);
        #2;
        if (!trst_n) m_reset();
        else m_clock();
        chk("R1 tdo", {31'd0, tdo}, {31'd0, m_frame[0]});
        chk("R6 R flag", {31'd0, core_rx_full}, {31'd0, m_r});
        chk("R6 down word", core_rdata, m_down);
        chk("R7 W flag", {31'd0, core_tx_full}, {31'd0, m_w});
        chk("R8 ctrl word", dbg_ctrl, m_ctl);
        chk("R8 wp value", wp0_value, m_wp);
        chk("R8 monitor", {31'd0, monitor_mode}, {31'd0, m_ctl[4]});
    endtask

    task automatic scan(input bit wr, input bit [4:0] a, input bit [31:0] d,
                        input bit cwr_cap, input bit crd_upd, output bit [31:0] got);
        bit [37:0] v = {wr, a, d};
        bit [31:0] exp;
        capture_dr = 1; core_wr = cwr_cap;
        step();
        exp = m_frame[31:0];
        capture_dr = 0; core_wr = 0;
        for (int i = 0; i < 38; i++) begin
            if (i < 32) got[i] = tdo;
            tdi = v[i]; shift_dr = 1;
            step();
        end
        shift_dr = 0; tdi = 0;
        update_dr = 1; core_rd = crd_upd;
        step();
        update_dr = 0; core_rd = 0;
        step();
        chk("R2 scan-out word", got, exp);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit [31:0] g;
        m_reset();
        step(); step();
        #5 trst_n = 1;
        step();
        chk("R10 ctrl after reset", dbg_ctrl, 32'h0);
        chk("R10 flags after reset", {30'd0, core_tx_full, core_rx_full}, 32'h0);

        scan(0, 5'd4, 32'h0, 0, 0, g);
        chk("R9 R10 addr0 reads zero", g, 32'h0);
        scan(0, 5'd4, 32'h0, 0, 0, g);
        chk("R5 version word", g, 32'h5000_0000);

        scan(1, 5'd9, 32'h0000_0012, 0, 0, g);
        chk("R2 write scan returns latched reg", g, 32'h5000_0000);
        chk("R3 R8 ctrl written", dbg_ctrl, 32'h0000_0012);
        chk("R8 monitor set", {31'd0, monitor_mode}, 32'd1);

        // stray strobes with no frame open
        tdi = 1; shift_dr = 1;
        for (int i = 0; i < 4; i++) step();
        shift_dr = 0; update_dr = 1; step(); update_dr = 0; tdi = 0; step();
        chk("R4 tdo unchanged", {31'd0, tdo}, 32'd0);

        scan(1, 5'd10, 32'hCAFE_0001, 0, 0, g);
        chk("R8 wp written", wp0_value, 32'hCAFE_0001);
        scan(1, 5'd3, 32'hFFFF_FFFF, 0, 0, g);
        scan(1, 5'd4, 32'hFFFF_FFFF, 0, 0, g);
        chk("R9 unmapped write ignored", dbg_ctrl, 32'h0000_0012);
        chk("R9 wp untouched", wp0_value, 32'hCAFE_0001);

        core_wdata = 32'hA5A5_0F0F; core_wr = 1; step(); core_wr = 0; step();
        chk("R7 W set", {31'd0, core_tx_full}, 32'd1);
        scan(0, 5'd5, 32'h0, 0, 0, g);
        chk("R5 R flag bits and ignored ctrl write", g, 32'h5000_0002);
        scan(0, 5'd4, 32'h0, 0, 0, g);
        chk("R7 up word read", g, 32'hA5A5_0F0F);
        chk("R7 W cleared by read", {31'd0, core_tx_full}, 32'd0);
        scan(0, 5'd4, 32'h0, 0, 0, g);
        scan(0, 5'd4, 32'h0, 0, 0, g);
        chk("R5 ctrl read repeatable", g, 32'h5000_0000);

        scan(1, 5'd5, 32'h1234_5678, 0, 0, g);
        chk("R6 R set", {31'd0, core_rx_full}, 32'd1);
        chk("R6 down word", core_rdata, 32'h1234_5678);
        core_rd = 1; step(); core_rd = 0; step();
        chk("R6 R cleared", {31'd0, core_rx_full}, 32'd0);

        scan(1, 5'd5, 32'h0000_DEAD, 0, 1, g);
        chk("R11 R set wins", {31'd0, core_rx_full}, 32'd1);
        scan(0, 5'd5, 32'h0, 0, 0, g);
        core_wdata = 32'h0BAD_F00D;
        scan(0, 5'd4, 32'h0, 1, 0, g);
        chk("R11 W set wins", {31'd0, core_tx_full}, 32'd1);
        scan(0, 5'd4, 32'h0, 0, 0, g);
        chk("R5 both flags", g, 32'h5000_0003);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule